// File: doc/BRIEF.md
# Write Protection Controller for a Byte Array and Control Registers

This block rules on every byte that a serial front end wants to store, either into a 256-byte nonvolatile array or into a small set of control registers. Each byte gets one of two answers: it is granted, or it is dropped without any error. Three pieces of protection state live inside the block. The first is a volatile enable latch. The second is a two-bit lock code that covers an upper region of the array. The third is a hardware-lock enable bit that works together with an external write-protect pin.

A command begins with `cmd_start`, which gives the target and a start address. Each data byte then arrives on `byte_vld`. The block checks each byte on its own, at the current address, and adds one to the address after every byte. The answer for a byte and the address it used appear on the ports one clock after that byte. The fault and status registers are always writable. The enable latch is controlled only by exact codes written to its register.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, `wel_o`, `bp_o`, `wpen_o`, `hw_lock_o`, `ack_ok` and `ack_drop` are all 0.
- R2: A byte to the latch target (tgt code 1) with data 80h sets the enable latch and is granted. A byte with data 00h clears the latch and is granted. The latch target is not gated by the latch itself.
- R3: A latch-target byte with any data other than 00h or 80h is dropped, and the latch keeps its value.
- R4: While the latch is 0, every array byte (tgt code 0) and every config-register byte (tgt code 2) is dropped.
- R5: A byte to the fault/status target (tgt code 3) is always granted, whatever the latch, the lock code or the hardware lock.
- R6: Lock code 00 protects no addresses. Code 01 protects C0h–FFh, code 10 protects 80h–FFh, and code 11 protects 00h–FFh. An array byte whose address lies in the protected region is dropped, even when the latch is set.
- R7: The config registers are selected by the low two address bits. Index 0 is the protection register: data bits [1:0] load the lock code and data bit 7 loads the hardware-lock enable. A granted byte to index 1, 2 or 3 stores nothing here.
- R8: The hardware lock is active when the synchronized pin and the hardware-lock enable are both 1. While it is active, config-register bytes are dropped and the lock code and enable do not change. Array bytes outside the protected region are still granted.
- R9: The answer for each byte appears on `ack_ok` or `ack_drop` one clock after the byte, never on both. `ack_addr` gives the byte's address. `cmd_start` loads the address (and is used by a byte in the same cycle). Each byte adds 1 to the address, wrapping modulo 256.
- R10: Within one command, only the first 16 array bytes can be granted. Later array bytes are dropped.
- R11: The pin passes through two flops. A change reaches `hw_lock_o` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | External write-protect pin, asynchronous |
| cmd_start | input | 1 | Starts a command: loads target and address |
| cmd_tgt | input | 2 | 0 array, 1 enable latch, 2 config registers, 3 fault/status |
| cmd_addr | input | 8 | Start address of the command |
| byte_vld | input | 1 | One data byte is offered this cycle |
| byte_data | input | 8 | Data byte |
| ack_ok | output | 1 | Previous byte granted |
| ack_drop | output | 1 | Previous byte silently dropped |
| ack_addr | output | 8 | Address the previous byte used |
| wel_o | output | 1 | Enable latch state |
| bp_o | output | 2 | Array lock code |
| wpen_o | output | 1 | Hardware-lock enable bit |
| hw_lock_o | output | 1 | Hardware lock currently active |

## Verification
The assertions are checked on every cycle. They cover these properties:
- no array or config byte is granted while the latch is clear;
- a byte inside the protected region, or a config byte under hardware lock, is always dropped;
- status bytes are always granted;
- the lock state holds still during hardware lock;
- the latch changes only on an exact-code write;
- the address steps by one after each byte.

Some behaviour shows only in the bench's scenarios, which compare against a model:
- the exact boundaries of each lock code;
- the 16-byte cap at the end of a long burst;
- the address wrap from FFh to 00h;
- the two-edge pin delay;
- whether a rejected code really leaves the latch untouched.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    TGT_ARRAY   = 2'd0,
    TGT_ENLATCH = 2'd1,
    TGT_CFG     = 2'd2,
    TGT_STAT    = 2'd3
  } tgt_e;

  localparam logic [7:0] EN_SET_CODE = 8'h80;
  localparam logic [7:0] EN_CLR_CODE = 8'h00;
  localparam int         WPEN_BIT    = 7;
  localparam logic [1:0] PROT_REG_IX = 2'd0;
endpackage

// File: rtl/wprot_sync.sv
module wprot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_async;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_BURST = 16,
  localparam int CNT_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  tgt_e              cmd_tgt,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  output tgt_e              eff_tgt,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              over_cap
);
  logic [ADDR_W-1:0] cur_addr, cur_addr_n;
  tgt_e              cur_tgt, cur_tgt_n;
  logic [CNT_W-1:0]  cnt, cnt_n, eff_cnt;
  logic              addr_en;

  always_comb begin
    eff_addr = cmd_start ? cmd_addr : cur_addr;
    eff_tgt  = cmd_start ? cmd_tgt  : cur_tgt;
    eff_cnt  = cmd_start ? '0 : cnt;
    over_cap = (eff_cnt >= CNT_W'(MAX_BURST));
  end

  always_comb begin
    addr_en    = cmd_start | byte_vld;
    cur_tgt_n  = eff_tgt;
    cur_addr_n = byte_vld ? eff_addr + ADDR_W'(1) : eff_addr;
    if (byte_vld && !over_cap) cnt_n = eff_cnt + CNT_W'(1);
    else                       cnt_n = eff_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_tgt  <= TGT_ARRAY;
      cnt      <= '0;
    end else if (addr_en) begin
      cur_addr <= cur_addr_n;
      cur_tgt  <= cur_tgt_n;
      cnt      <= cnt_n;
    end
  end

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> cur_addr == ADDR_W'($past(eff_addr) + ADDR_W'(1)));

  // R10
  cap_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_BURST));
endmodule

// File: rtl/wprot_region.sv
module wprot_region #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_blk
);
  logic [1:0] top2;
  assign top2 = addr[ADDR_W-1 -: 2];

  always_comb begin
    unique case (bp)
      2'b00:   in_blk = 1'b0;
      2'b01:   in_blk = (top2 == 2'b11);
      2'b10:   in_blk = top2[1];
      default: in_blk = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
  import wprot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              prot_ld,
  input  logic [DATA_W-1:0] prot_data,
  input  logic              pin_sync,
  output logic              wel,
  output logic [1:0]        bp,
  output logic              wpen,
  output logic              hw_lock
);
  logic       wel_n, wpen_n, wel_en;
  logic [1:0] bp_n;

  always_comb begin
    wel_en = wel_set | wel_clr;
    wel_n  = wel_set;
    bp_n   = prot_data[1:0];
    wpen_n = prot_data[WPEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (wel_en) wel <= wel_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp   <= 2'b00;
      wpen <= 1'b0;
    end else if (prot_ld) begin
      bp   <= bp_n;
      wpen <= wpen_n;
    end
  end

  assign hw_lock = pin_sync & wpen;

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> $stable(bp) && $stable(wpen));

  // R3
  wel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> $past(wel_set || wel_clr));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int MAX_BURST   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_tgt,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  output logic              ack_ok,
  output logic              ack_drop,
  output logic [ADDR_W-1:0] ack_addr,
  output logic              wel_o,
  output logic [1:0]        bp_o,
  output logic              wpen_o,
  output logic              hw_lock_o
);
  tgt_e              eff_tgt;
  logic [ADDR_W-1:0] eff_addr;
  logic              over_cap, in_blk, pin_sync;
  logic              wel, wpen, hw_lock;
  logic [1:0]        bp;
  logic              grant, wel_set, wel_clr, prot_ld;
  logic              ack_ok_n, ack_drop_n;

  wprot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(wp_pin), .q_sync(pin_sync));

  wprot_seq #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_tgt(tgt_e'(cmd_tgt)),
    .cmd_addr(cmd_addr), .byte_vld(byte_vld), .eff_tgt(eff_tgt),
    .eff_addr(eff_addr), .over_cap(over_cap));

  wprot_region #(.ADDR_W(ADDR_W)) u_region (
    .bp(bp), .addr(eff_addr), .in_blk(in_blk));

  wprot_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .prot_ld(prot_ld), .prot_data(byte_data), .pin_sync(pin_sync),
    .wel(wel), .bp(bp), .wpen(wpen), .hw_lock(hw_lock));

  always_comb begin
    grant   = 1'b0;
    wel_set = 1'b0;
    wel_clr = 1'b0;
    prot_ld = 1'b0;
    unique case (eff_tgt)
      TGT_ARRAY: grant = wel & ~in_blk & ~over_cap;
      TGT_ENLATCH: begin
        grant   = (byte_data == DATA_W'(EN_SET_CODE)) ||
                  (byte_data == DATA_W'(EN_CLR_CODE));
        wel_set = byte_vld & (byte_data == DATA_W'(EN_SET_CODE));
        wel_clr = byte_vld & (byte_data == DATA_W'(EN_CLR_CODE));
      end
      TGT_CFG: begin
        grant   = wel & ~hw_lock;
        prot_ld = byte_vld & grant & (eff_addr[1:0] == PROT_REG_IX);
      end
      default: grant = 1'b1;
    endcase
    ack_ok_n   = byte_vld & grant;
    ack_drop_n = byte_vld & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_ok   <= 1'b0;
      ack_drop <= 1'b0;
    end else begin
      ack_ok   <= ack_ok_n;
      ack_drop <= ack_drop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_addr <= '0;
    else if (byte_vld) ack_addr <= eff_addr;
  end

  assign wel_o     = wel;
  assign bp_o      = bp;
  assign wpen_o    = wpen;
  assign hw_lock_o = hw_lock;

  // R4
  nowel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !wel && (eff_tgt == TGT_ARRAY || eff_tgt == TGT_CFG) |=> ack_drop);

  // R6
  blk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && eff_tgt == TGT_ARRAY && in_blk |=> ack_drop);

  // R8
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && eff_tgt == TGT_CFG && hw_lock |=> ack_drop && $stable(bp));

  // R5
  stat_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && eff_tgt == TGT_STAT |=> ack_ok);

  // R9
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_ok && ack_drop));
endmodule

// File: tb/wprot_ctrl_bench.sv
`timescale 1ns/1ps
module wprot_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wp_pin, cmd_start, byte_vld;
  logic [1:0] cmd_tgt;
  logic [7:0] cmd_addr, byte_data;
  logic       ack_ok, ack_drop, wel_o, wpen_o, hw_lock_o;
  logic [7:0] ack_addr;
  logic [1:0] bp_o;

  int n_chk = 0;
  int n_fail = 0;
  int seed_v;

  logic       m_wel, m_wpen, m_wp;
  logic [1:0] m_bp;
  logic [7:0] m_addr;
  int         m_cnt;

  always #2.5 clk = ~clk;

  wprot_ctrl u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cmd_start(cmd_start),
    .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr), .byte_vld(byte_vld),
    .byte_data(byte_data), .ack_ok(ack_ok), .ack_drop(ack_drop),
    .ack_addr(ack_addr), .wel_o(wel_o), .bp_o(bp_o), .wpen_o(wpen_o),
    .hw_lock_o(hw_lock_o));

  function automatic logic region_hit(input logic [1:0] bp, input logic [7:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 8'hC0;
      2'b10:   return a >= 8'h80;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_byte(input logic start, input logic [1:0] tgt,
                         input logic [7:0] addr, input logic [7:0] data);
    logic  g;
    string tag;
    logic [7:0] a;
    @(negedge clk);
    cmd_start = start; cmd_tgt = tgt; cmd_addr = addr;
    byte_vld = 1'b1; byte_data = data;
    if (start) begin m_addr = addr; m_cnt = 0; end
    a = m_addr;
    case (tgt)
      2'd0: begin
        g = m_wel && !region_hit(m_bp, a) && (m_cnt < 16);
        tag = (m_cnt >= 16) ? "R10" : (region_hit(m_bp, a) ? "R6" : "R4");
      end
      2'd1: begin
        g = (data == 8'h80) || (data == 8'h00);
        tag = g ? "R2" : "R3";
        if (g) m_wel = (data == 8'h80);
      end
      2'd2: begin
        g = m_wel && !(m_wp && m_wpen);
        tag = (m_wp && m_wpen) ? "R8" : "R7";
        if (g && a[1:0] == 2'd0) begin m_bp = data[1:0]; m_wpen = data[7]; end
      end
      default: begin g = 1'b1; tag = "R5"; end
    endcase
    if (m_cnt < 16) m_cnt++;
    m_addr = a + 8'd1;
    @(negedge clk);
    cmd_start = 1'b0; byte_vld = 1'b0;
    check(tag, {14'd0, ack_ok, ack_drop}, {14'd0, g, !g});
    check("R9", {8'd0, ack_addr}, {8'd0, a});
    check("R7", {12'd0, wel_o, bp_o, wpen_o}, {12'd0, m_wel, m_bp, m_wpen});
  endtask

  task automatic set_pin(input logic v);
    logic old_lock;
    old_lock = m_wp && m_wpen;
    @(negedge clk);
    wp_pin = v;
    @(negedge clk);
    check("R11", {15'd0, hw_lock_o}, {15'd0, old_lock});
    @(negedge clk);
    m_wp = v;
    check("R11", {15'd0, hw_lock_o}, {15'd0, m_wp && m_wpen});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_v = 1234;
    void'($urandom(seed_v));
    rst_n = 1'b0; wp_pin = 1'b0; cmd_start = 1'b0; byte_vld = 1'b0;
    cmd_tgt = 2'd0; cmd_addr = 8'd0; byte_data = 8'd0;
    m_wel = 0; m_wpen = 0; m_wp = 0; m_bp = 0; m_addr = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {10'd0, wel_o, bp_o, wpen_o, hw_lock_o, ack_ok, ack_drop},
          16'd0);
    // R4 latch clear: array and cfg dropped
    do_byte(1, 2'd0, 8'h10, 8'hAA);
    do_byte(1, 2'd2, 8'h00, 8'h03);
    // R5 status always ok
    do_byte(1, 2'd3, 8'h01, 8'h55);
    // R3 bad code, R2 set
    do_byte(1, 2'd1, 8'h00, 8'h81);
    do_byte(1, 2'd1, 8'h00, 8'h80);
    do_byte(1, 2'd1, 8'h00, 8'h40);
    do_byte(1, 2'd0, 8'hFF, 8'h11);
    // R6 each lock code at its edges
    do_byte(1, 2'd2, 8'h00, 8'h01);
    do_byte(1, 2'd0, 8'hC0, 8'h00);
    do_byte(1, 2'd0, 8'hBF, 8'h00);
    do_byte(1, 2'd2, 8'h00, 8'h02);
    do_byte(1, 2'd0, 8'h80, 8'h00);
    do_byte(1, 2'd0, 8'h7F, 8'h00);
    do_byte(1, 2'd2, 8'h00, 8'h03);
    do_byte(1, 2'd0, 8'h00, 8'h00);
    // R7 non-zero index stores nothing
    do_byte(1, 2'd2, 8'h01, 8'h83);
    do_byte(1, 2'd2, 8'h00, 8'h00);
    // R10 and R9: 18-byte burst wrapping past FFh
    for (int i = 0; i < 18; i++) do_byte(i == 0, 2'd0, 8'hF8, 8'(i));
    // R8 hardware lock
    do_byte(1, 2'd2, 8'h00, 8'h81);
    set_pin(1'b1);
    do_byte(1, 2'd2, 8'h00, 8'h00);
    do_byte(1, 2'd0, 8'h40, 8'h77);
    do_byte(1, 2'd0, 8'hC4, 8'h77);
    set_pin(1'b0);
    do_byte(1, 2'd2, 8'h00, 8'h00);
    // R2 clear then R4
    do_byte(1, 2'd1, 8'h00, 8'h00);
    do_byte(1, 2'd0, 8'h20, 8'h00);
    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] t;
      int len;
      logic [7:0] ad;
      if ($urandom_range(0, 9) == 0) set_pin(~m_wp);
      t = 2'($urandom_range(0, 3));
      ad = 8'($urandom);
      len = (t == 2'd0) ? $urandom_range(1, 20) : $urandom_range(1, 3);
      for (int b = 0; b < len; b++) begin
        logic [7:0] d;
        int pick;
        pick = $urandom_range(0, 3);
        d = 8'($urandom);
        if (t == 2'd1) d = (pick == 0) ? 8'h00 : (pick == 3 ? d : 8'h80);
        do_byte(b == 0, t, ad, d);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule